// File: doc/BRIEF.md
# Sixteen-Way Butterfly Request Network

This block carries single-flit write-style requests from sixteen initiator ports to sixteen target ports. Each request holds a 24-bit address and a data word. The most significant hex digit of the address names the target: a request addressed to 0x5xxxxx ends up on target port 5. Both edges of the block use a valid/ready handshake. An initiator holds its request until ready is high in the same cycle, and a target accepts a request by raising ready.

Inside, four stages of two-input, two-output switches are wired as a radix-2 butterfly, with eight switches per stage. Each switch reads the top hex digit of the arriving address and looks it up in its own sixteen-entry, one-bit routing table to choose the lower (0) or upper (1) output. The tables are computed at elaboration. Every switch output owns a one-entry register slice, so an unblocked request moves one stage per cycle.

When both inputs of a switch want the same output, a round-robin arbiter picks one of them. The other input sees ready low and waits. A stalled target therefore pushes back through the stages to the initiators without dropping anything.

Top module: `bfly_net`

## Requirements
- R1: After reset, and while no request has been accepted, every target valid is low.
- R2: A request accepted from any initiator is presented on the target port whose index equals address bits [23:20]. Its address and data arrive unchanged.
- R3: Every accepted request is delivered exactly once. Nothing is lost and nothing is duplicated.
- R4: Requests from one initiator to one target are delivered in the order the initiator issued them.
- R5: With no contention and the target ready, a request accepted at a clock edge is presented at the target after the third following edge. In bench terms, it is visible four cycles after the acceptance cycle.
- R6: While a target valid is high and its ready is low, that target's valid, address and data stay unchanged.
- R7: After reset each arbiter first favours its lower input. When both inputs keep requesting the same output, grants alternate between them. Initiators 0 and 8 streaming to target 0 arrive as 0, 8, 0, 8, and so on.
- R8: With one target held not-ready, an initiator streaming to it has exactly four requests accepted, one per stage slice, before its ready stays low. At no time are more than 64 requests in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ini_valid | input | 16 | Request valid, one bit per initiator |
| ini_ready | output | 16 | Request accepted this cycle, one bit per initiator |
| ini_addr | input | 384 | 24-bit address per initiator; initiator i at bits [24i+23:24i] |
| ini_data | input | 256 | 16-bit payload per initiator; initiator i at bits [16i+15:16i] |
| tgt_valid | output | 16 | Request presented, one bit per target |
| tgt_ready | input | 16 | Target takes the presented request |
| tgt_addr | output | 384 | Address presented to each target, same packing as ini_addr |
| tgt_data | output | 256 | Payload presented to each target, same packing as ini_data |

## Verification
The assertions check three properties on every cycle. Each target only ever sees addresses whose top digit matches its own index. A stalled target's outputs hold still. The count of requests in flight never exceeds the sixty-four slices.

Exactly-once delivery, per-pair ordering and the four-cycle latency can only be shown by the bench's scoreboard. The alternating arbitration order and the four-slot fill under a blocked target also need the bench. The scoreboard tags each payload with its source and a per-pair sequence number.

// File: rtl/bfly_net.sv
module bfly_net #(
  parameter int LOG_N = 4,
  parameter int AW = 24,
  parameter int DW = 16,
  localparam int N = 1 << LOG_N
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    ini_valid,
  output logic [N-1:0]    ini_ready,
  input  logic [N*AW-1:0] ini_addr,
  input  logic [N*DW-1:0] ini_data,
  output logic [N-1:0]    tgt_valid,
  input  logic [N-1:0]    tgt_ready,
  output logic [N*AW-1:0] tgt_addr,
  output logic [N*DW-1:0] tgt_data
);
  localparam int S = LOG_N;
  localparam int FW = AW + DW;

  function automatic logic [N-1:0] route_tbl(int b);
    logic [N-1:0] t;
    for (int d = 0; d < N; d++) t[d] = ((d >> b) & 1) == 1;
    return t;
  endfunction

  logic          lv [0:S][0:N-1];
  logic [FW-1:0] lf [0:S][0:N-1];
  logic          lr [0:S][0:N-1];

  for (genvar i = 0; i < N; i++) begin : g_edge
    assign lv[0][i] = ini_valid[i];
    assign lf[0][i] = {ini_addr[i*AW +: AW], ini_data[i*DW +: DW]};
    assign ini_ready[i] = lr[0][i];
    assign tgt_valid[i] = lv[S][i];
    assign tgt_addr[i*AW +: AW] = lf[S][i][FW-1 -: AW];
    assign tgt_data[i*DW +: DW] = lf[S][i][DW-1:0];
    assign lr[S][i] = tgt_ready[i];
  end

  for (genvar s = 0; s < S; s++) begin : g_stage
    for (genvar k = 0; k < N/2; k++) begin : g_sw
      localparam int B = S - 1 - s;
      localparam int LO = ((k >> B) << (B + 1)) | (k & ((1 << B) - 1));
      localparam int HI = LO + (1 << B);
      localparam logic [N-1:0] RT = route_tbl(B);

      logic [1:0] sel, gnt_a, gnt_b, ok;
      assign sel[0] = RT[lf[s][LO][FW-1 -: LOG_N]];
      assign sel[1] = RT[lf[s][HI][FW-1 -: LOG_N]];

      for (genvar o = 0; o < 2; o++) begin : g_out
        localparam int OL = (o == 0) ? LO : HI;
        logic ra, rb, pri, rv;
        logic [FW-1:0] rf;
        assign ra = lv[s][LO] && (sel[0] == 1'(o));
        assign rb = lv[s][HI] && (sel[1] == 1'(o));
        assign ok[o] = !rv || lr[s+1][OL];
        assign gnt_a[o] = ra && (!rb || !pri);
        assign gnt_b[o] = rb && (!ra || pri);

        always_ff @(posedge clk) begin
          if (!rst_n) begin
            rv  <= 1'b0;
            pri <= 1'b0;
          end else if (ok[o]) begin
            rv <= gnt_a[o] | gnt_b[o];
            if (gnt_a[o] | gnt_b[o]) pri <= gnt_a[o];
          end
        end

        always_ff @(posedge clk)
          if (ok[o] && (gnt_a[o] || gnt_b[o]))
            rf <= gnt_a[o] ? lf[s][LO] : lf[s][HI];

        assign lv[s+1][OL] = rv;
        assign lf[s+1][OL] = rf;
      end

      assign lr[s][LO] = gnt_a[sel[0]] && ok[sel[0]];
      assign lr[s][HI] = gnt_b[sel[1]] && ok[sel[1]];
    end
  end
endmodule

// File: rtl/bfly_net_chk.sv
module bfly_net_chk #(
  parameter int LOG_N = 4,
  parameter int AW = 24,
  parameter int DW = 16,
  localparam int N = 1 << LOG_N
) (
  input logic            clk,
  input logic            rst_n,
  input logic [N-1:0]    ini_valid,
  input logic [N-1:0]    ini_ready,
  input logic [N*AW-1:0] ini_addr,
  input logic [N*DW-1:0] ini_data,
  input logic [N-1:0]    tgt_valid,
  input logic [N-1:0]    tgt_ready,
  input logic [N*AW-1:0] tgt_addr,
  input logic [N*DW-1:0] tgt_data
);
  logic [15:0] inflight;

  always_ff @(posedge clk) begin
    if (!rst_n) inflight <= '0;
    else inflight <= inflight + 16'($countones(ini_valid & ini_ready))
                              - 16'($countones(tgt_valid & tgt_ready));
  end

  AST_INFLIGHT_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    inflight <= 16'(N * LOG_N)); // R8

  for (genvar i = 0; i < N; i++) begin : g_lane
    AST_TGT_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_valid[i] |-> tgt_addr[i*AW+AW-1 -: LOG_N] == LOG_N'(i)); // R2
    AST_TGT_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_valid[i] && !tgt_ready[i] |=> tgt_valid[i]); // R6
    AST_TGT_HOLD_FLIT: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_valid[i] && !tgt_ready[i] |=>
        $stable(tgt_addr[i*AW +: AW]) && $stable(tgt_data[i*DW +: DW])); // R6
  end
endmodule

bind bfly_net bfly_net_chk #(.LOG_N(LOG_N), .AW(AW), .DW(DW)) u_chk (.*);

// File: tb/bfly_net_bench.sv
`timescale 1ns/1ps
module bfly_net_bench;
  localparam int N = 16;
  localparam int AW = 24;
  localparam int DW = 16;

  logic clk = 0;
  logic rst_n = 0;
  logic [N-1:0] ini_valid = '0, ini_ready, tgt_valid, tgt_ready = '0;
  logic [N*AW-1:0] ini_addr = '0, tgt_addr;
  logic [N*DW-1:0] ini_data = '0, tgt_data;

  always #5 clk = ~clk;

  bfly_net #(.LOG_N(4), .AW(AW), .DW(DW)) u_bfly_net (
    .clk(clk), .rst_n(rst_n), .ini_valid(ini_valid), .ini_ready(ini_ready),
    .ini_addr(ini_addr), .ini_data(ini_data), .tgt_valid(tgt_valid),
    .tgt_ready(tgt_ready), .tgt_addr(tgt_addr), .tgt_data(tgt_data));

  int checks = 0, fails = 0, cyc = 0;
  int pend_v[N], pend_t[N], gen_en[N], force_t[N], tr_fix[N];
  int fired[N], fire_cnt[N], last_fire[N];
  int seq[N][N], nxt[N][N], sent[N], rcvd[N];
  int gen_pct = 0, tr_pct = 100;
  int lat_mode = 0, lat_seen = 0, log_en = 0, log_n = 0;
  int log_src[64];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic deliver(input int t);
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    int src, sq;
    a = tgt_addr[t*AW +: AW];
    d = tgt_data[t*DW +: DW];
    src = int'(d[15:12]);
    sq = int'(d[11:0]);
    chk(int'(a[23:20]) == t, "R2 target digit", int'(a[23:20]), t);
    chk(a[15:0] == d, "R2 payload intact", int'(a[15:0]), int'(d));
    chk(sq == nxt[src][t], "R4 order/R3 no loss", sq, nxt[src][t]);
    nxt[src][t] = sq + 1;
    rcvd[t]++;
    if (lat_mode != 0) begin
      chk(cyc - last_fire[src] == 4, "R5 latency", cyc - last_fire[src], 4);
      lat_seen++;
    end
    if (log_en != 0 && t == 0 && log_n < 64) begin
      log_src[log_n] = src;
      log_n++;
    end
  endtask

  task automatic cycle();
    @(negedge clk);
    cyc++;
    for (int i = 0; i < N; i++) begin
      if (fired[i] != 0) pend_v[i] = 0;
      if (pend_v[i] == 0 && gen_en[i] != 0 && $urandom_range(99) < gen_pct) begin
        pend_v[i] = 1;
        pend_t[i] = (force_t[i] >= 0) ? force_t[i] : int'($urandom_range(N-1));
      end
      ini_valid[i] = pend_v[i] != 0;
      ini_data[i*DW +: DW] = {4'(i), 12'(seq[i][pend_t[i]])};
      ini_addr[i*AW +: AW] = {4'(pend_t[i]), 4'h0, 4'(i), 12'(seq[i][pend_t[i]])};
    end
    for (int t = 0; t < N; t++)
      tgt_ready[t] = (tr_fix[t] >= 0) ? (tr_fix[t] != 0) : ($urandom_range(99) < tr_pct);
    #1;
    for (int i = 0; i < N; i++) begin
      fired[i] = int'(ini_valid[i] && ini_ready[i]);
      if (fired[i] != 0) begin
        seq[i][pend_t[i]]++;
        sent[pend_t[i]]++;
        fire_cnt[i]++;
        last_fire[i] = cyc;
      end
    end
    for (int t = 0; t < N; t++)
      if (tgt_valid[t] && tgt_ready[t]) deliver(t);
  endtask

  task automatic run(input int n);
    for (int k = 0; k < n; k++) cycle();
  endtask

  task automatic gen_off();
    for (int i = 0; i < N; i++) begin
      gen_en[i] = 0;
      force_t[i] = -1;
    end
  endtask

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [AW-1:0] held_a;
    int base;
    void'($urandom(2024));
    for (int i = 0; i < N; i++) begin
      pend_v[i] = 0; pend_t[i] = 0; gen_en[i] = 0; force_t[i] = -1; tr_fix[i] = 1;
      fired[i] = 0; fire_cnt[i] = 0; last_fire[i] = 0; sent[i] = 0; rcvd[i] = 0;
      for (int j = 0; j < N; j++) begin seq[i][j] = 0; nxt[i][j] = 0; end
    end
    run(3);
    rst_n = 1;
    run(2);
    chk(tgt_valid == '0, "R1 reset idle", int'(tgt_valid), 0);

    // R7: initiators 0 and 8 contend for target 0
    gen_pct = 100;
    gen_en[0] = 1; force_t[0] = 0;
    gen_en[8] = 1; force_t[8] = 0;
    log_en = 1;
    run(16);
    gen_off();
    run(10);
    log_en = 0;
    for (int k = 0; k < 8; k++)
      chk(log_src[k] == ((k % 2 == 1) ? 8 : 0), "R7 alternation", log_src[k], (k % 2 == 1) ? 8 : 0);

    // R5: single uncontended request 3 -> 9
    lat_mode = 1;
    gen_en[3] = 1; force_t[3] = 9;
    cycle();
    gen_off();
    run(10);
    lat_mode = 0;
    chk(lat_seen == 1, "R5 delivered once", lat_seen, 1);

    // R8 and R6: target 5 blocked
    tr_fix[5] = 0;
    base = fire_cnt[0];
    gen_en[0] = 1; force_t[0] = 5;
    run(10);
    held_a = tgt_addr[5*AW +: AW];
    run(10);
    chk(fire_cnt[0] - base == 4, "R8 four slots", fire_cnt[0] - base, 4);
    chk(tgt_valid[5] && tgt_addr[5*AW +: AW] == held_a, "R6 held while stalled",
        int'(tgt_addr[5*AW +: AW]), int'(held_a));
    gen_off();
    tr_fix[5] = 1;
    run(15);

    // Random traffic with random target backpressure
    gen_pct = 60;
    tr_pct = 70;
    for (int i = 0; i < N; i++) begin gen_en[i] = 1; tr_fix[i] = -1; end
    run(3000);
    gen_off();
    for (int i = 0; i < N; i++) tr_fix[i] = 1;
    run(80);
    for (int t = 0; t < N; t++)
      chk(rcvd[t] == sent[t], "R3 exactly once", rcvd[t], sent[t]);
    chk(tgt_valid == '0, "R3 drained", int'(tgt_valid), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule